// File: doc/BRIEF.md
# Compare-Action Down Timer

The block is a pair of down-counting timer halves, each able to drive an output pin when it reaches its time-out point. Each half holds a reload value and a 3-bit action code. When the count reaches zero it raises a time-out flag. It also sets, clears or toggles its pin, as the code selects. Some codes also force the pin to a chosen level at the moment the code is written. This lets software fix the pin's starting level and then pick the edge that the next time-out produces. Codes may be rewritten while the timer runs.

The halves run independently in split mode. In concatenated mode half A becomes one counter of twice the width, and only pin 0 is driven. Half B's counter and pin are then idle. The time-out flag is shared with ordinary timer use. It reaches the interrupt output only through its mask bit, and it is cleared by a clear strobe.

Top module: `cmp_action_timer`

## Requirements
- R1: After reset both pins are 0, both time-out flags are clear and `irq` is 0.
- R2: A half that is enabled (`en_wr` with `en_val`=1) loads its counter from its reload register and counts down once per clock. Periodic mode is `cfg_mode`=2'b10. In this mode it signals a time-out on the clock after the counter reaches zero, reloads, and so times out every reload+1 cycles. The first time-out is reload+1 cycles after the enabling edge.
- R3: In one-shot mode (`cfg_mode`=2'b01) a half times out once, then clears its own enable and raises no further time-out.
- R4: At a time-out where the compare action is allowed, the registered code acts on the pin. Codes 1, 4 and 5 toggle the pin, codes 2 and 6 clear it, codes 3 and 7 set it, and code 0 leaves it alone.
- R5: A code write with bit 2 set forces the pin on the clock edge that samples the write. Codes 4 and 6 force it to 1, and codes 5 and 7 force it to 0. If the same edge also carries a time-out action, the forced level wins.
- R6: No pin action, immediate or at time-out, happens unless `cfg_mode` is one-shot or periodic and `cfg_capture` is 0. PWM mode (2'b11) counts periodically but never moves a pin. Mode 2'b00 holds the counters.
- R7: In concatenated mode (`cfg_wide`=1) half A counts from the 32-bit reload {reload B, reload A}. Its time-outs set flag 0 only. Pin 1 does not change, whatever code is written to half B.
- R8: In split mode each half has its own 16-bit count, flag, code and pin, with no effect on the other half.
- R9: A code written while a half runs governs that half's next time-out.
- R10: `irq[i]` is the flag of half i ANDed with `int_mask[i]`. The flag stays set until an `int_clr[i]` strobe clears it.
- R11: If a clear strobe and a new time-out fall on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 00 hold, 01 one-shot, 10 periodic, 11 PWM |
| cfg_capture | input | 1 | 1 selects capture, which blocks pin actions |
| cfg_wide | input | 1 | 1 concatenates both halves into half A |
| act_wr | input | 2 | Code write strobe, bit i for half i |
| act_code | input | 6 | Action code, bits [3i+2:3i] for half i |
| ld_wr | input | 2 | Reload write strobe per half |
| ld_val | input | 32 | Reload values, half A low, half B high |
| en_wr | input | 2 | Enable write strobe per half |
| en_val | input | 2 | Enable value written by `en_wr` |
| int_mask | input | 2 | Interrupt mask per half |
| int_clr | input | 2 | Flag clear strobe per half |
| ccp_pin | output | 2 | Compare-action pins, bit 0 for half A |
| irq | output | 2 | Masked time-out interrupt per half |

## Verification
The collision of interest is a flag clear arriving on the same edge as a fresh time-out. A second one is a code write landing on the same edge as a time-out action. The first is provoked by a reload of zero in periodic mode, which times out on every clock, while the clear strobe is held. The interrupt must stay high, and it may drop only once the counter is stopped. The second comes up often under random stimulus with short reloads and frequent code writes. Each cycle there is judged against a reference model in which an immediate force overrides the time-out action and the time-out uses the code held before the write.

// File: rtl/cat_pkg.sv
`timescale 1ns/1ps
package cat_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD     = 2'b00,
        MODE_ONESHOT  = 2'b01,
        MODE_PERIODIC = 2'b10,
        MODE_PWM      = 2'b11
    } cat_mode_e;

    // Pin level produced by a time-out action for a given code.
    function automatic logic tmo_level(input logic [2:0] code, input logic cur);
        logic lvl;
        case (code)
            3'd1, 3'd4, 3'd5: lvl = ~cur;
            3'd2, 3'd6:       lvl = 1'b0;
            3'd3, 3'd7:       lvl = 1'b1;
            default:          lvl = cur;
        endcase
        return lvl;
    endfunction

    // Codes with bit 2 set force the pin when written; bit 0 picks the low level.
    function automatic logic force_level(input logic [2:0] code);
        return ~code[0];
    endfunction

endpackage

// File: rtl/cat_counter.sv
`timescale 1ns/1ps
module cat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_ok,
    input  logic         one_shot,
    input  logic         en_wr,
    input  logic         en_val,
    input  logic [W-1:0] reload,
    input  logic         int_clr,
    output logic         tmo,
    output logic         flag
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         en;
        logic         flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tmo  = st_q.en && run_ok && (st_q.cnt == '0);
        if (tmo) begin
            if (one_shot) st_d.en  = 1'b0;
            else          st_d.cnt = reload;
        end else if (st_q.en && run_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (en_wr) begin
            st_d.en = en_val;
            if (en_val) st_d.cnt = reload;
        end
        if (int_clr) st_d.flag = 1'b0;
        if (tmo)     st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R3
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && one_shot && !en_wr) |=> !st_q.en);

    // R11
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !tmo) |=> !flag);

endmodule

// File: rtl/cat_pin.sv
`timescale 1ns/1ps
module cat_pin
    import cat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       allow,
    input  logic       act_wr,
    input  logic [2:0] act_new,
    input  logic       tmo,
    output logic       pin
);

    typedef struct packed {
        logic [2:0] act;
        logic       pin;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tmo && allow && (st_q.act != 3'd0))
            st_d.pin = tmo_level(st_q.act, st_q.pin);
        if (act_wr) begin
            st_d.act = act_new;
            if (allow && act_new[2]) st_d.pin = force_level(act_new);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;

    // R5
    force_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_wr && allow && act_new[2]) |=> (pin == !$past(act_new[0])));

    // R6
    blocked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> $stable(pin));

endmodule

// File: rtl/cmp_action_timer.sv
`timescale 1ns/1ps
module cmp_action_timer
    import cat_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_capture,
    input  logic                cfg_wide,
    input  logic [1:0]          act_wr,
    input  logic [5:0]          act_code,
    input  logic [1:0]          ld_wr,
    input  logic [2*HALF_W-1:0] ld_val,
    input  logic [1:0]          en_wr,
    input  logic [1:0]          en_val,
    input  logic [1:0]          int_mask,
    input  logic [1:0]          int_clr,
    output logic [1:0]          ccp_pin,
    output logic [1:0]          irq
);

    localparam int FULL_W = 2 * HALF_W;
    localparam int NHALF  = 2;

    typedef struct packed {
        logic [HALF_W-1:0] ld_b;
        logic [HALF_W-1:0] ld_a;
    } ld_regs_t;

    ld_regs_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (ld_wr[0]) ld_d.ld_a = ld_val[HALF_W-1:0];
        if (ld_wr[1]) ld_d.ld_b = ld_val[FULL_W-1:HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    cat_mode_e mode;
    logic      counting, one_shot, cmp_ok;
    logic [FULL_W-1:0] reload_a;
    logic [NHALF-1:0]  tmo, flag, pin_allow;

    assign mode     = cat_mode_e'(cfg_mode);
    assign counting = (mode != MODE_HOLD);
    assign one_shot = (mode == MODE_ONESHOT);
    assign cmp_ok   = ((mode == MODE_ONESHOT) || (mode == MODE_PERIODIC)) && !cfg_capture;
    assign reload_a = cfg_wide ? {ld_q.ld_b, ld_q.ld_a} : {{HALF_W{1'b0}}, ld_q.ld_a};

    cat_counter #(.W(FULL_W)) u_cnt_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok   (counting),
        .one_shot (one_shot),
        .en_wr    (en_wr[0]),
        .en_val   (en_val[0]),
        .reload   (reload_a),
        .int_clr  (int_clr[0]),
        .tmo      (tmo[0]),
        .flag     (flag[0])
    );

    cat_counter #(.W(HALF_W)) u_cnt_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok   (counting && !cfg_wide),
        .one_shot (one_shot),
        .en_wr    (en_wr[1]),
        .en_val   (en_val[1]),
        .reload   (ld_q.ld_b),
        .int_clr  (int_clr[1]),
        .tmo      (tmo[1]),
        .flag     (flag[1])
    );

    for (genvar g = 0; g < NHALF; g++) begin : g_pin
        assign pin_allow[g] = cmp_ok && ((g == 0) || !cfg_wide);
        cat_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .allow   (pin_allow[g]),
            .act_wr  (act_wr[g]),
            .act_new (act_code[3*g +: 3]),
            .tmo     (tmo[g]),
            .pin     (ccp_pin[g])
        );
    end

    assign irq = flag & int_mask;

    // R7
    wide_pin_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wide |=> $stable(ccp_pin[1]));

    // R7
    wide_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wide |-> !tmo[1]);

endmodule

// File: tb/cmp_action_timer_test.sv
`timescale 1ns/1ps
module cmp_action_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_capture = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [1:0]  act_wr = '0;
    logic [5:0]  act_code = '0;
    logic [1:0]  ld_wr = '0;
    logic [31:0] ld_val = '0;
    logic [1:0]  en_wr = '0;
    logic [1:0]  en_val = '0;
    logic [1:0]  int_mask = '0;
    logic [1:0]  int_clr = '0;
    logic [1:0]  ccp_pin, irq;

    int nvec = 0, nfail = 0;
    bit done = 1'b0;

    // reference state
    logic [1:0]  m_pin = '0, m_flag = '0, m_en = '0;
    logic [2:0]  m_act [2];
    logic [31:0] m_cnt [2];
    logic [15:0] m_ld  [2];

    always #2.5 clk = ~clk;

    cmp_action_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_capture(cfg_capture),
        .cfg_wide(cfg_wide), .act_wr(act_wr), .act_code(act_code), .ld_wr(ld_wr),
        .ld_val(ld_val), .en_wr(en_wr), .en_val(en_val), .int_mask(int_mask),
        .int_clr(int_clr), .ccp_pin(ccp_pin), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            logic runok, allow, t;
            logic [31:0] ld;
            logic [2:0]  ai;
            runok = (cfg_mode != 2'b00) && (i == 0 || !cfg_wide);
            allow = (cfg_mode == 2'b01 || cfg_mode == 2'b10) && !cfg_capture && (i == 0 || !cfg_wide);
            ld    = (i == 0) ? (cfg_wide ? {m_ld[1], m_ld[0]} : {16'h0, m_ld[0]}) : {16'h0, m_ld[1]};
            ai    = act_code[3*i +: 3];
            t     = m_en[i] && runok && (m_cnt[i] == 0);
            if (t && allow) begin
                case (m_act[i])
                    3'd1, 3'd4, 3'd5: m_pin[i] = ~m_pin[i];
                    3'd2, 3'd6:       m_pin[i] = 1'b0;
                    3'd3, 3'd7:       m_pin[i] = 1'b1;
                    default: ;
                endcase
            end
            if (act_wr[i]) begin
                if (allow && ai[2]) m_pin[i] = ~ai[0];
                m_act[i] = ai;
            end
            if (t) begin
                if (cfg_mode == 2'b01) m_en[i] = 1'b0;
                else                   m_cnt[i] = ld;
            end else if (m_en[i] && runok) begin
                m_cnt[i] = m_cnt[i] - 1;
            end
            if (en_wr[i]) begin
                m_en[i] = en_val[i];
                if (en_val[i]) m_cnt[i] = ld;
            end
            if (int_clr[i]) m_flag[i] = 1'b0;
            if (t)          m_flag[i] = 1'b1;
        end
        if (ld_wr[0]) m_ld[0] = ld_val[15:0];
        if (ld_wr[1]) m_ld[1] = ld_val[31:16];
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, {30'h0, ccp_pin, irq} & 32'hF, {28'h0, m_pin, m_flag & int_mask});
        act_wr = '0; ld_wr = '0; en_wr = '0; int_clr = '0;
    endtask

    task automatic wr_act(int h, logic [2:0] code);
        act_wr[h] = 1'b1;
        act_code[3*h +: 3] = code;
    endtask

    task automatic wr_ld(int h, logic [15:0] v);
        ld_wr[h] = 1'b1;
        ld_val[16*h +: 16] = v;
    endtask

    task automatic wr_en(int h, logic v);
        en_wr[h] = 1'b1;
        en_val[h] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c7a));
        for (int i = 0; i < 2; i++) begin
            m_act[i] = '0; m_cnt[i] = '0; m_ld[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pins", {30'h0, ccp_pin}, 32'h0);
        check("R1 irq", {30'h0, irq}, 32'h0);

        // R5 immediate forcing
        cfg_mode = 2'b10; int_mask = 2'b11;
        wr_act(0, 3'd6); tick("R5");
        check("R5 code6 pin0", {31'h0, ccp_pin[0]}, 32'h1);
        wr_act(0, 3'd7); tick("R5");
        check("R5 code7 pin0", {31'h0, ccp_pin[0]}, 32'h0);
        wr_act(1, 3'd4); tick("R5");
        check("R5 code4 pin1", {31'h0, ccp_pin[1]}, 32'h1);
        wr_act(1, 3'd5); tick("R5");
        check("R5 code5 pin1", {31'h0, ccp_pin[1]}, 32'h0);

        // R6 blocked in PWM and capture
        cfg_mode = 2'b11; wr_act(0, 3'd6); tick("R6");
        check("R6 pwm force", {31'h0, ccp_pin[0]}, 32'h0);
        cfg_mode = 2'b10; cfg_capture = 1'b1; wr_act(0, 3'd4); tick("R6");
        check("R6 capture force", {31'h0, ccp_pin[0]}, 32'h0);
        cfg_capture = 1'b0;

        // R2 first time-out after reload+1 cycles
        wr_act(0, 3'd0); wr_ld(0, 16'd3); tick("R2");
        wr_en(0, 1'b1); tick("R2");
        for (int k = 0; k < 3; k++) begin
            tick("R2");
            check("R2 no early tmo", {31'h0, irq[0]}, 32'h0);
        end
        tick("R2");
        check("R2 tmo at L+1", {31'h0, irq[0]}, 32'h1);
        wr_en(0, 1'b0); int_clr[0] = 1'b1; tick("R2");

        // R9 code change while running
        wr_ld(0, 16'd2); tick("R9");
        wr_en(0, 1'b1); wr_act(0, 3'd3); tick("R9");
        repeat (3) tick("R9");
        check("R9 set at tmo", {31'h0, ccp_pin[0]}, 32'h1);
        wr_act(0, 3'd2); tick("R9");
        repeat (2) tick("R9");
        check("R9 clear at next tmo", {31'h0, ccp_pin[0]}, 32'h0);

        // R11 clear and time-out on the same edge
        wr_ld(0, 16'd0); wr_en(0, 1'b1); tick("R11");
        repeat (2) tick("R11");
        int_clr[0] = 1'b1; tick("R11");
        check("R11 set wins", {31'h0, irq[0]}, 32'h1);
        // R10 mask and clear
        wr_en(0, 1'b0); tick("R10");
        int_mask = 2'b10; tick("R10");
        check("R10 masked", {31'h0, irq[0]}, 32'h0);
        int_mask = 2'b11; tick("R10");
        check("R10 held", {31'h0, irq[0]}, 32'h1);
        int_clr[0] = 1'b1; tick("R10");
        check("R10 cleared", {31'h0, irq[0]}, 32'h0);

        // R3 one-shot
        cfg_mode = 2'b01; wr_ld(0, 16'd2); tick("R3");
        wr_en(0, 1'b1); tick("R3");
        repeat (3) tick("R3");
        check("R3 single tmo", {31'h0, irq[0]}, 32'h1);
        int_clr[0] = 1'b1; tick("R3");
        repeat (10) tick("R3");
        check("R3 stopped", {31'h0, irq[0]}, 32'h0);

        // R7 concatenated mode
        cfg_mode = 2'b10; cfg_wide = 1'b1;
        wr_ld(0, 16'd0); wr_ld(1, 16'd1); wr_act(0, 3'd1); tick("R7");
        wr_act(1, 3'd4); wr_en(0, 1'b1); tick("R7");
        check("R7 pin1 ignores code", {31'h0, ccp_pin[1]}, 32'h0);
        repeat (65536) tick("R7");
        check("R7 no tmo before 65537", {31'h0, irq[0]}, 32'h0);
        tick("R7");
        check("R7 wide tmo", {31'h0, irq[0]}, 32'h1);
        check("R7 pin0 toggled", {31'h0, ccp_pin[0]}, 32'h1);
        check("R7 pin1 still", {31'h0, ccp_pin[1]}, 32'h0);
        wr_en(0, 1'b0); int_clr = 2'b11; tick("R7");

        // R4/R8 random phase
        for (int seg = 0; seg < 8; seg++) begin
            int r;
            r = $urandom_range(0, 9);
            cfg_mode    = (r < 4) ? 2'b10 : (r < 7) ? 2'b01 : 2'(r % 4);
            cfg_capture = ($urandom_range(0, 5) == 0);
            cfg_wide    = ($urandom_range(0, 3) == 0);
            int_mask    = 2'($urandom_range(0, 3));
            if (cfg_wide) wr_ld(1, 16'd0);
            tick("R4/R8");
            for (int c = 0; c < 600; c++) begin
                for (int h = 0; h < 2; h++) begin
                    if ($urandom_range(0, 7) == 0) wr_act(h, 3'($urandom_range(0, 7)));
                    if ($urandom_range(0, 9) == 0)
                        wr_ld(h, (cfg_wide && h == 1) ? 16'd0 : 16'($urandom_range(0, 7)));
                    if ($urandom_range(0, 19) == 0) wr_en(h, $urandom_range(0, 3) != 0);
                    if ($urandom_range(0, 5) == 0) int_clr[h] = 1'b1;
                end
                tick("R4/R8");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule